// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a parameterised set of external interrupt lines (32 by default) and turns each one into a pending bit. Each line is first brought into the clock domain by a flop chain. It is then judged according to three per-source settings. The first chooses level or edge sensing. The second chooses the active sense: high or low for a level, rising or falling for an edge. The third lets an edge source react to both edges.

Software works through a plain 32-bit register bus. It can force or withdraw an interrupt by number through a single command register. It changes enable (mask) bits only through separate write-one-to-set and write-one-to-clear vectors, so a mask update never needs a read-modify-write sequence. The enable and pending vectors can be read back.

Every source has its own route register. This register can send the source to one of the numbered output pins, to the non-maskable output, or to both. An output is raised while any enabled, pending source routed to it remains pending.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset the polarity, trigger, dual-edge, enable and route registers all read 0. No held pending state remains. With every line high, the pending vector reads 0, and all pin outputs and the non-maskable output are low.
- R2: Each line passes through a SYNC_STAGES-flop synchroniser (default 2) before any sensing. A line change made between two clock edges reaches a routed output after the second following edge and not after the first.
- R3: A source whose trigger bit is 0 (trigger vector at 0x180) is level-sensed. With polarity bit 1 (polarity vector at 0x100), its pending bit equals the synchronised line. With polarity bit 0, it equals the inverse of that line.
- R4: A source with trigger bit 1 and dual-edge bit 0 (dual-edge vector at 0x200) sets its pending bit on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The opposite edge has no effect. The bit stays set until software clears it.
- R5: A source with trigger bit 1 and dual-edge bit 1 sets its pending bit on either edge, whatever its polarity bit holds.
- R6: A write to 0x280 acts on the source numbered by data bits 7:0. With bit 31 at 1 it sets that source's held pending state. With bit 31 at 0 it clears that state. A number at or above NUM_SRC changes nothing.
- R7: Ones written to 0x380 set the matching enable bits, and ones written to 0x300 clear them. Zero bits leave enables unchanged. Enables read at 0x400, pending at 0x480, and the set and clear addresses read 0. Bits beyond NUM_SRC read 0.
- R8: Source i sits in bit i%32 of word i/32 of each per-source vector. Word k lies at the vector's offset plus 4*k.
- R9: The route register of source i is at 0x500 + 4*i. Bit 31 enables pin routing, bit 30 enables non-maskable routing, and bits 5:0 hold the pin number. All other bits read 0.
- R10: Pin p is high while any source that is pending and enabled, has route bit 31 set and has pin number p is present. A pin number at or above NUM_PINS drives no pin.
- R11: The non-maskable output is high while any pending, enabled source with route bit 30 set is present, independent of bit 31.
- R12: Read data appears after the clock edge that samples the read strobe and holds until the next read. Unassigned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_SRC | Asynchronous interrupt request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_pin_o | output | NUM_PINS | Routed interrupt pins |
| irq_nmi_o | output | 1 | Non-maskable interrupt output |

## Verification
The bench drives edge sources through the edge that must be ignored and then through the edge that must count. A design that watched the wrong edge, or let a held bit fall when the line returned, would show a wrong pending bit at once. It sends a command to a source number past the end and writes all ones to the partly used upper enable word. A decoder that wrapped the number or stored bits beyond the last source would change a bit that should stay 0. On the routing side, it points a source at a pin number past the last pin and samples a routed output one edge and two edges after a line change. A design with a short synchroniser, a truncated pin compare or an NMI path tied to bit 31 would show a wrong output value.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

   localparam int unsigned BUS_W       = 32;
   localparam int unsigned ADDR_W      = 12;
   localparam int unsigned PIN_NUM_W   = 6;
   localparam int unsigned WEDGE_NUM_W = 8;
   localparam int unsigned VEC_BITS    = 32;

   // register offsets; software decodes these, so they are fixed
   localparam logic [ADDR_W-1:0] OFS_POL   = 12'h100;
   localparam logic [ADDR_W-1:0] OFS_TRIG  = 12'h180;
   localparam logic [ADDR_W-1:0] OFS_DUAL  = 12'h200;
   localparam logic [ADDR_W-1:0] OFS_WEDGE = 12'h280;
   localparam logic [ADDR_W-1:0] OFS_MCLR  = 12'h300;
   localparam logic [ADDR_W-1:0] OFS_MSET  = 12'h380;
   localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h400;
   localparam logic [ADDR_W-1:0] OFS_PEND  = 12'h480;
   localparam logic [ADDR_W-1:0] OFS_MAP   = 12'h500;

   localparam int unsigned WEDGE_SET_BIT = 31;
   localparam int unsigned MAP_PIN_BIT   = 31;
   localparam int unsigned MAP_NMI_BIT   = 30;

   typedef struct packed {
      logic                 pin_en;
      logic                 nmi_en;
      logic [PIN_NUM_W-1:0] pin;
   } route_t;

   function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                   input int unsigned       k);
      return base + ADDR_W'(4 * k);
   endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < int'(STAGES); s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic pol_i,
   input  logic trig_i,
   input  logic dual_i,
   input  logic wset_i,
   input  logic wclr_i,
   output logic pend_o
);

   logic prev_q;
   logic held_q;
   logic rise, fall, edge_hit, level_hit;

   assign rise      = line_i & ~prev_q;
   assign fall      = ~line_i & prev_q;
   assign edge_hit  = trig_i & (dual_i ? (rise | fall) : (pol_i ? rise : fall));
   assign level_hit = ~trig_i & ~(line_i ^ pol_i);

   // a fresh edge or a software set wins over a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         held_q <= 1'b0;
      end else begin
         prev_q <= line_i;
         held_q <= edge_hit | wset_i | (held_q & ~wclr_i);
      end
   end

   assign pend_o = held_q | level_hit;

endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
   import irq_src_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_i,
   input  logic                     rd_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [BUS_W-1:0]         wdata_i,
   input  logic [NUM_SRC-1:0]       pend_i,
   output logic [BUS_W-1:0]         rdata_o,
   output logic [NUM_SRC-1:0]       pol_o,
   output logic [NUM_SRC-1:0]       trig_o,
   output logic [NUM_SRC-1:0]       dual_o,
   output logic [NUM_SRC-1:0]       mask_o,
   output logic [NUM_SRC-1:0]       wset_o,
   output logic [NUM_SRC-1:0]       wclr_o,
   output route_t [NUM_SRC-1:0]     route_o
);

   localparam int unsigned NWORDS = (NUM_SRC + VEC_BITS - 1) / VEC_BITS;
   localparam int unsigned VEC_W  = NWORDS * VEC_BITS;
   localparam logic [VEC_W-1:0] VALID = VEC_W'({NUM_SRC{1'b1}});

   logic [VEC_W-1:0]        pol_q, trig_q, dual_q, mask_q;
   logic [VEC_W-1:0]        pend_pad;
   route_t [NUM_SRC-1:0]    route_q;
   logic [BUS_W-1:0]        rd_val, rdata_q;
   logic [WEDGE_NUM_W-1:0]  wedge_num;
   logic                    wedge_hit;

   assign pend_pad = VEC_W'(pend_i);

   // configuration, enable and route storage
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pol_q   <= '0;
         trig_q  <= '0;
         dual_q  <= '0;
         mask_q  <= '0;
         route_q <= '0;
      end else if (wr_i) begin
         for (int unsigned k = 0; k < NWORDS; k++) begin
            if (addr_i == word_addr(OFS_POL, k))
               pol_q[k*VEC_BITS +: VEC_BITS] <= wdata_i & VALID[k*VEC_BITS +: VEC_BITS];
            if (addr_i == word_addr(OFS_TRIG, k))
               trig_q[k*VEC_BITS +: VEC_BITS] <= wdata_i & VALID[k*VEC_BITS +: VEC_BITS];
            if (addr_i == word_addr(OFS_DUAL, k))
               dual_q[k*VEC_BITS +: VEC_BITS] <= wdata_i & VALID[k*VEC_BITS +: VEC_BITS];
            if (addr_i == word_addr(OFS_MCLR, k))
               mask_q[k*VEC_BITS +: VEC_BITS] <= mask_q[k*VEC_BITS +: VEC_BITS] & ~wdata_i;
            if (addr_i == word_addr(OFS_MSET, k))
               mask_q[k*VEC_BITS +: VEC_BITS] <= mask_q[k*VEC_BITS +: VEC_BITS]
                                                 | (wdata_i & VALID[k*VEC_BITS +: VEC_BITS]);
         end
         for (int unsigned i = 0; i < NUM_SRC; i++) begin
            if (addr_i == word_addr(OFS_MAP, i))
               route_q[i] <= {wdata_i[MAP_PIN_BIT], wdata_i[MAP_NMI_BIT], wdata_i[PIN_NUM_W-1:0]};
         end
      end
   end

   // software set / clear command, decoded into one-hot pulses
   assign wedge_num = wdata_i[WEDGE_NUM_W-1:0];
   assign wedge_hit = wr_i && (addr_i == OFS_WEDGE);

   always_comb begin
      wset_o = '0;
      wclr_o = '0;
      for (int unsigned i = 0; i < NUM_SRC; i++) begin
         if (wedge_hit && (wedge_num == WEDGE_NUM_W'(i))) begin
            wset_o[i] = wdata_i[WEDGE_SET_BIT];
            wclr_o[i] = ~wdata_i[WEDGE_SET_BIT];
         end
      end
   end

   // read mux
   always_comb begin
      rd_val = '0;
      for (int unsigned k = 0; k < NWORDS; k++) begin
         if (addr_i == word_addr(OFS_POL, k))  rd_val = pol_q[k*VEC_BITS +: VEC_BITS];
         if (addr_i == word_addr(OFS_TRIG, k)) rd_val = trig_q[k*VEC_BITS +: VEC_BITS];
         if (addr_i == word_addr(OFS_DUAL, k)) rd_val = dual_q[k*VEC_BITS +: VEC_BITS];
         if (addr_i == word_addr(OFS_MASK, k)) rd_val = mask_q[k*VEC_BITS +: VEC_BITS];
         if (addr_i == word_addr(OFS_PEND, k)) rd_val = pend_pad[k*VEC_BITS +: VEC_BITS];
      end
      for (int unsigned i = 0; i < NUM_SRC; i++) begin
         if (addr_i == word_addr(OFS_MAP, i))
            rd_val = {route_q[i].pin_en, route_q[i].nmi_en,
                      {(BUS_W-2-PIN_NUM_W){1'b0}}, route_q[i].pin};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_val;
   end

   assign rdata_o = rdata_q;
   assign pol_o   = pol_q[NUM_SRC-1:0];
   assign trig_o  = trig_q[NUM_SRC-1:0];
   assign dual_o  = dual_q[NUM_SRC-1:0];
   assign mask_o  = mask_q[NUM_SRC-1:0];
   assign route_o = route_q;

endmodule

// File: rtl/irq_src_route.sv
module irq_src_route
   import irq_src_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 32,
   parameter int unsigned NUM_PINS = 8,
   parameter bit          OUT_REG  = 1'b0
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_SRC-1:0]    act_i,
   input  route_t [NUM_SRC-1:0]  route_i,
   output logic [NUM_PINS-1:0]   pin_o,
   output logic                  nmi_o
);

   logic [NUM_PINS-1:0] pin_d;
   logic                nmi_d;

   always_comb begin
      pin_d = '0;
      nmi_d = 1'b0;
      for (int unsigned i = 0; i < NUM_SRC; i++) begin
         if (act_i[i]) begin
            if (route_i[i].nmi_en) nmi_d = 1'b1;
            if (route_i[i].pin_en) begin
               for (int unsigned p = 0; p < NUM_PINS; p++) begin
                  if (route_i[i].pin == PIN_NUM_W'(p)) pin_d[p] = 1'b1;
               end
            end
         end
      end
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pin_o <= '0;
            nmi_o <= 1'b0;
         end else begin
            pin_o <= pin_d;
            nmi_o <= nmi_d;
         end
      end
   end else begin : g_out_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign pin_o = pin_d;
      assign nmi_o = nmi_d;
   end

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
   import irq_src_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OUT_REG     = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_SRC-1:0]   irq_lines_i,
   input  logic                 bus_wr_i,
   input  logic                 bus_rd_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic [BUS_W-1:0]     bus_wdata_i,
   output logic [BUS_W-1:0]     bus_rdata_o,
   output logic [NUM_PINS-1:0]  irq_pin_o,
   output logic                 irq_nmi_o
);

   // elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > (1 << WEDGE_NUM_W)) begin : g_bad_src
      $error("NUM_SRC must lie in 1..256");
   end
   if (NUM_PINS < 1 || NUM_PINS > (1 << PIN_NUM_W)) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0]   line_sync;
   logic [NUM_SRC-1:0]   pol_vec, trig_vec, dual_vec, mask_vec;
   logic [NUM_SRC-1:0]   wset_vec, wclr_vec, pend_vec;
   route_t [NUM_SRC-1:0] route_vec;

   irq_src_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (irq_lines_i),
      .q_o    (line_sync)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      irq_src_cell u_cell (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .line_i (line_sync[i]),
         .pol_i  (pol_vec[i]),
         .trig_i (trig_vec[i]),
         .dual_i (dual_vec[i]),
         .wset_i (wset_vec[i]),
         .wclr_i (wclr_vec[i]),
         .pend_o (pend_vec[i])
      );
   end

   irq_src_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bus_wr_i),
      .rd_i    (bus_rd_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .pend_i  (pend_vec),
      .rdata_o (bus_rdata_o),
      .pol_o   (pol_vec),
      .trig_o  (trig_vec),
      .dual_o  (dual_vec),
      .mask_o  (mask_vec),
      .wset_o  (wset_vec),
      .wclr_o  (wclr_vec),
      .route_o (route_vec)
   );

   irq_src_route #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS), .OUT_REG(OUT_REG)) u_route (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (pend_vec & mask_vec),
      .route_i (route_vec),
      .pin_o   (irq_pin_o),
      .nmi_o   (irq_nmi_o)
   );

endmodule

// File: rtl/irq_src_chk.sv
module irq_src_chk #(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                bus_wr_i,
   input logic [NUM_SRC-1:0]  irq_lines_i,
   input logic [NUM_SRC-1:0]  line_sync,
   input logic [NUM_SRC-1:0]  pol_vec,
   input logic [NUM_SRC-1:0]  trig_vec,
   input logic [NUM_SRC-1:0]  mask_vec,
   input logic [NUM_SRC-1:0]  pend_vec,
   input logic [NUM_PINS-1:0] irq_pin_o,
   input logic                irq_nmi_o
);

   logic [1:0] age_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             age_q <= '0;
      else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
   end

   // R2
   if (SYNC_STAGES == 2) begin : g_sync2
      sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (age_q >= 2'd2) |-> (line_sync == $past(irq_lines_i, 2)));
   end

   // R3
   level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((~trig_vec & ~(line_sync ^ pol_vec) & ~pend_vec) == '0));

   // R4
   edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_wr_i |=> ((($past(pend_vec) & $past(trig_vec)) & ~pend_vec) == '0));

   // R7
   mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_wr_i |=> $stable(mask_vec));

   // R10
   quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mask_vec == '0) && $past(mask_vec == '0)) |-> ((irq_pin_o == '0) && !irq_nmi_o));

endmodule

bind irq_src_ctrl irq_src_chk #(
   .NUM_SRC     (NUM_SRC),
   .NUM_PINS    (NUM_PINS),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_wr_i    (bus_wr_i),
   .irq_lines_i (irq_lines_i),
   .line_sync   (line_sync),
   .pol_vec     (pol_vec),
   .trig_vec    (trig_vec),
   .mask_vec    (mask_vec),
   .pend_vec    (pend_vec),
   .irq_pin_o   (irq_pin_o),
   .irq_nmi_o   (irq_nmi_o)
);

// File: tb/irq_src_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_src_ctrl_tb_top;

   localparam int NS = 40;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] lines = '1;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pins;
   logic          nmi;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [31:0] pol_w [2];
   logic [31:0] trig_w [2];
   logic [31:0] dual_w [2];

   always #2.5 clk = ~clk;

   irq_src_ctrl #(.NUM_SRC(NS), .NUM_PINS(NP)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .irq_lines_i (lines),
      .bus_wr_i    (bus_wr),
      .bus_rd_i    (bus_rd),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_pin_o   (pins),
      .irq_nmi_o   (nmi)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_line(input int idx, input logic v);
      @(negedge clk);
      lines[idx] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic cfg(input logic [11:0] base, input int idx, input logic v);
      int w;
      logic [31:0] val;
      w = idx / 32;
      val = '0;
      case (base)
         12'h100: begin pol_w[w][idx%32]  = v; val = pol_w[w];  end
         12'h180: begin trig_w[w][idx%32] = v; val = trig_w[w]; end
         default: begin dual_w[w][idx%32] = v; val = dual_w[w]; end
      endcase
      wr(base + 12'(4 * w), val);
   endtask

   task automatic chk_pend(input string tag, input int idx, input logic exp);
      logic [31:0] d;
      rd(12'h480 + 12'(4 * (idx / 32)), d);
      check(tag, {31'b0, d[idx%32]}, {31'b0, exp});
   endtask

   // R1
   task automatic t_reset;
      logic [31:0] d;
      for (int k = 0; k < 2; k++) begin
         rd(12'h100 + 12'(4*k), d); check("R1 polarity", d, 0);
         rd(12'h180 + 12'(4*k), d); check("R1 trigger", d, 0);
         rd(12'h200 + 12'(4*k), d); check("R1 dual", d, 0);
         rd(12'h400 + 12'(4*k), d); check("R1 enable", d, 0);
         rd(12'h480 + 12'(4*k), d); check("R1 pending", d, 0);
      end
      rd(12'h500, d);          check("R1 route 0", d, 0);
      rd(12'h500 + 12'(4*39), d); check("R1 route 39", d, 0);
      check("R1 pins", {24'b0, pins}, 0);
      check("R1 nmi", {31'b0, nmi}, 0);
   endtask

   // R2, R10: source 0 active-high level routed to pin 0
   task automatic t_sync;
      set_line(0, 1'b0);
      cfg(12'h100, 0, 1'b1);
      wr(12'h380, 32'h1);
      wr(12'h500, 32'h8000_0000);
      check("R10 pin idle", {24'b0, pins}, 0);
      @(negedge clk); lines[0] = 1'b1;
      @(negedge clk);
      check("R2 one edge after change", {24'b0, pins}, 0);
      @(negedge clk);
      check("R2 two edges after change", {24'b0, pins}, 32'h1);
      set_line(0, 1'b0);
      check("R10 pin drops with line", {24'b0, pins}, 0);
      wr(12'h300, 32'h1);
   endtask

   // R3
   task automatic t_level;
      chk_pend("R3 low-active idle", 1, 1'b0);
      set_line(1, 1'b0);
      chk_pend("R3 low-active asserted", 1, 1'b1);
      set_line(1, 1'b1);
      chk_pend("R3 low-active released", 1, 1'b0);
      set_line(0, 1'b1);
      chk_pend("R3 high-active asserted", 0, 1'b1);
      set_line(0, 1'b0);
      chk_pend("R3 high-active released", 0, 1'b0);
   endtask

   // R4
   task automatic t_edge;
      cfg(12'h180, 2, 1'b1);
      cfg(12'h100, 2, 1'b1);
      set_line(2, 1'b0);
      chk_pend("R4 falling ignored on rising source", 2, 1'b0);
      set_line(2, 1'b1);
      chk_pend("R4 rising sets", 2, 1'b1);
      set_line(2, 1'b0);
      chk_pend("R4 held after line falls", 2, 1'b1);
      wr(12'h280, 32'd2);
      chk_pend("R4 cleared by command", 2, 1'b0);
      cfg(12'h180, 3, 1'b1);
      set_line(3, 1'b0);
      chk_pend("R4 falling sets falling source", 3, 1'b1);
      wr(12'h280, 32'd3);
      set_line(3, 1'b1);
      chk_pend("R4 rising ignored on falling source", 3, 1'b0);
   endtask

   // R5
   task automatic t_dual;
      cfg(12'h180, 4, 1'b1);
      cfg(12'h200, 4, 1'b1);
      set_line(4, 1'b0);
      chk_pend("R5 falling sets", 4, 1'b1);
      wr(12'h280, 32'd4);
      chk_pend("R5 cleared", 4, 1'b0);
      set_line(4, 1'b1);
      chk_pend("R5 rising sets", 4, 1'b1);
      wr(12'h280, 32'd4);
   endtask

   // R6
   task automatic t_wedge;
      logic [31:0] d;
      chk_pend("R6 idle", 5, 1'b0);
      wr(12'h280, 32'h8000_0005);
      chk_pend("R6 software set", 5, 1'b1);
      wr(12'h280, 32'h0000_0005);
      chk_pend("R6 software clear", 5, 1'b0);
      wr(12'h280, 32'h8000_00C8);
      rd(12'h480, d); check("R6 out of range word0", d, 0);
      rd(12'h484, d); check("R6 out of range word1", d, 0);
   endtask

   // R8
   task automatic t_pack;
      logic [31:0] d;
      cfg(12'h180, 37, 1'b1);
      cfg(12'h100, 37, 1'b1);
      set_line(37, 1'b0);
      set_line(37, 1'b1);
      rd(12'h484, d); check("R8 source 37 in word1 bit5", d, 32'h20);
      rd(12'h480, d); check("R8 word0 untouched", d, 0);
      wr(12'h280, 32'h8000_0023);
      rd(12'h484, d); check("R8 source 35 in word1 bit3", d, 32'h28);
      wr(12'h280, 32'd37);
      wr(12'h280, 32'd35);
      rd(12'h484, d); check("R8 word1 cleared", d, 0);
   endtask

   // R7
   task automatic t_mask;
      logic [31:0] d;
      wr(12'h380, 32'hF0);
      rd(12'h400, d); check("R7 set ones", d, 32'hF0);
      wr(12'h300, 32'h30);
      rd(12'h400, d); check("R7 clear ones", d, 32'hC0);
      wr(12'h380, 32'h0);
      rd(12'h400, d); check("R7 zero write keeps", d, 32'hC0);
      rd(12'h300, d); check("R7 clear reg reads 0", d, 0);
      rd(12'h380, d); check("R7 set reg reads 0", d, 0);
      wr(12'h384, 32'hFFFF_FFFF);
      rd(12'h404, d); check("R7 upper word only valid bits", d, 32'hFF);
      wr(12'h300, 32'hFFFF_FFFF);
      wr(12'h304, 32'hFFFF_FFFF);
      rd(12'h400, d); check("R7 all cleared", d, 0);
   endtask

   // R9, R10, R11
   task automatic t_route;
      logic [31:0] d;
      wr(12'h518, 32'hFFFF_FFFF);
      rd(12'h518, d); check("R9 route fields", d, 32'hC000_003F);
      wr(12'h280, 32'h8000_0006);
      wr(12'h380, 32'h40);
      wr(12'h518, 32'h8000_0003);
      check("R10 pin 3", {24'b0, pins}, 32'h08);
      check("R11 nmi off", {31'b0, nmi}, 0);
      wr(12'h518, 32'h4000_0003);
      check("R10 pin routing off", {24'b0, pins}, 0);
      check("R11 nmi on", {31'b0, nmi}, 1);
      wr(12'h518, 32'hC000_0009);
      check("R10 pin past last", {24'b0, pins}, 0);
      check("R11 nmi with both bits", {31'b0, nmi}, 1);
      wr(12'h518, 32'hC000_0005);
      check("R10 pin 5", {24'b0, pins}, 32'h20);
      wr(12'h59C, 32'h8000_0005);
      wr(12'h280, 32'h8000_0027);
      wr(12'h384, 32'h80);
      wr(12'h300, 32'h40);
      check("R10 pin 5 from second source", {24'b0, pins}, 32'h20);
      check("R11 nmi off after disable", {31'b0, nmi}, 0);
      wr(12'h280, 32'd39);
      check("R10 pin 5 released", {24'b0, pins}, 0);
   endtask

   // R12
   task automatic t_read;
      logic [31:0] d;
      rd(12'h7FC, d); check("R12 unassigned", d, 0);
      rd(12'h280, d); check("R12 command reg", d, 0);
      rd(12'h518, d); check("R12 read value", d, 32'hC000_0005);
      repeat (3) @(negedge clk);
      check("R12 data held", bus_rdata, 32'hC000_0005);
   endtask

   initial begin
      for (int k = 0; k < 2; k++) begin
         pol_w[k] = '0; trig_w[k] = '0; dual_w[k] = '0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_sync();
      t_level();
      t_edge();
      t_dual();
      t_wedge();
      t_pack();
      t_mask();
      t_route();
      t_read();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule